// File: doc/BRIEF.md
# Byte-Wide Serial Bus Target with Clock Hold

This block is the target side of a two-wire serial bus (I2C, 7-bit addressing) for a small processor's serial port. It samples the clock and data lines with the system clock through a two-flop synchronizer. It recognises bus start and stop conditions and shifts in the first byte after a start. It compares the upper seven bits of that byte with a programmable own address, and it then either receives bytes from the bus controller or transmits bytes to it.

The processor side sees a single byte buffer together with a set of flags: full, overflow, per-byte event and read direction. It also has a release bit. When the bus controller reads, the target holds the clock line low after every acknowledged byte. The processor must write the next byte into the buffer and then set the release bit. Only then does the target let the clock go and shift the byte out.

Both bus lines are open-drain. The block therefore outputs one pull-low enable per line, and the surrounding pad logic or the bench forms the wired-AND with the other drivers on the bus.

Top module: `i2c_slave_stretch`

## Requirements
- R1: After reset both pull-low outputs are 0 and the buffer, full flag, overflow flag, event flag, direction bit and release bit all read 0.
- R2: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. A STOP sends the target back to idle from any state, releases both lines on the next cycle and clears the direction bit.
- R3: After a START, the first seven received bits (MSB first) are compared with `own_addr_i`, and the eighth bit is the direction (1 = read). On a mismatch the target gives no ACK, raises no event and ignores every following byte until the next START.
- R4: A matched address byte, or any later received byte, is taken when the buffer is not full. It is written whole into the buffer, the full flag is set, and SDA is pulled low for the ninth clock as ACK.
- R5: If a byte (a matched address or a data byte) ends while the full flag is set, the overflow flag is set, SDA is not pulled on the ninth clock and the buffer keeps its previous contents.
- R6: The event flag is set on the ninth falling SCL edge of every byte that follows a matched address, including refused bytes, received bytes and transmitted bytes. It stays set until `irq_clr_i` is pulsed.
- R7: A one-cycle pulse on `buf_rd_i` clears the full flag.
- R8: On a matched address with direction 1, the direction bit becomes 1, the address byte is placed in the buffer, ACK is given, and SCL is held low from the ninth falling edge.
- R9: While SCL is held, a `rel_set_i` pulse sets the release bit only if the buffer has been written since the hold began. If the buffer has not been written, the pulse has no effect and SCL stays held. Once the release bit is set, SCL is freed on the next cycle.
- R10: The release bit is cleared by the block itself on the cycle each hold of SCL begins.
- R11: In transmit, the written byte leaves MSB first. SDA changes only while the synchronized SCL is low.
- R12: The bus controller's acknowledge is sampled on the ninth rising SCL edge. If it is low (ACK), SCL is held again. If it is high (NACK), SCL stays free, the direction bit and full flag are cleared and the target waits for a START.
- R13: The outputs `scl_pull_o` and `sda_pull_o` are pull-low enables: 1 drives the line to 0 and 0 leaves it released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Resolved SCL line level |
| sda_i | input | 1 | Resolved SDA line level |
| scl_pull_o | output | 1 | Pull SCL low when 1 |
| sda_pull_o | output | 1 | Pull SDA low when 1 |
| own_addr_i | input | 7 | Own bus address |
| buf_wdata_i | input | 8 | Byte written by the processor |
| buf_wr_i | input | 1 | Buffer write strobe, also loads the transmit shifter |
| buf_rd_i | input | 1 | Buffer read strobe, clears the full flag |
| buf_rdata_o | output | 8 | Buffer contents |
| buf_full_o | output | 1 | Buffer holds an unread received byte |
| ovf_o | output | 1 | Byte refused because the buffer was full |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| irq_o | output | 1 | Per-byte event flag |
| irq_clr_i | input | 1 | Clears the event flag |
| rel_set_i | input | 1 | Request to free a held SCL |
| rel_o | output | 1 | Release bit |
| rw_o | output | 1 | Direction of the current transfer (1 = read) |

## Verification
The properties assume a well-behaved bus controller. It changes SDA only while SCL is low, except when it forms START or STOP, and it never issues STOP while the target holds SCL. They also assume the processor does not write the buffer in the same cycle that a byte is refused. The bench drives the bus with fixed half-periods of twenty system clocks and moves SDA a few cycles after each SCL fall. It raises SCL only after the line is seen high, and it issues STOP only after a NACK or a write. Processor strobes are one-cycle pulses given while the bus is quiet.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,   // waiting for START
      ST_RECV,   // shifting in a byte
      ST_ACK,    // ninth clock of a received byte
      ST_HOLD,   // SCL held low for the processor
      ST_SEND,   // shifting out a byte
      ST_MACK,   // ninth clock of a sent byte
      ST_SKIP    // not addressed, wait for START
   } st_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2cs_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < W; i++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
   end
endmodule

// File: rtl/i2cs_events.sv
module i2cs_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   // processor side
   input  logic [DW-1:0] wdata,
   input  logic          wr,
   input  logic          rd,
   input  logic          irq_clr,
   input  logic          ovf_clr,
   input  logic          rel_set,
   // protocol side
   input  logic          rx_load,
   input  logic [DW-1:0] rx_data,
   input  logic          rw_load,
   input  logic          rw_val,
   input  logic          rw_clr,
   input  logic          irq_set,
   input  logic          ovf_set,
   input  logic          hold_begin,
   input  logic          idle_reset,
   input  logic          tx_shift,
   // state
   output logic [DW-1:0] buf_q,
   output logic          full,
   output logic          ovf,
   output logic          irq,
   output logic          rw,
   output logic          rel,
   output logic          loaded,
   output logic          tx_msb
);
   logic [DW-1:0] tx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q  <= '0;
         tx_sh  <= '0;
         full   <= 1'b0;
         ovf    <= 1'b0;
         irq    <= 1'b0;
         rw     <= 1'b0;
         rel    <= 1'b0;
         loaded <= 1'b0;
      end else begin
         if (rx_load)  buf_q <= rx_data;
         else if (wr)  buf_q <= wdata;

         if (wr)            tx_sh <= wdata;
         else if (tx_shift) tx_sh <= {tx_sh[DW-2:0], 1'b0};

         if (rx_load)               full <= 1'b1;
         else if (rd || idle_reset) full <= 1'b0;

         if (ovf_set)      ovf <= 1'b1;
         else if (ovf_clr) ovf <= 1'b0;

         if (irq_set)      irq <= 1'b1;
         else if (irq_clr) irq <= 1'b0;

         if (idle_reset || rw_clr) rw <= 1'b0;
         else if (rw_load)         rw <= rw_val;

         if (wr)              loaded <= 1'b1;
         else if (hold_begin) loaded <= 1'b0;

         if (hold_begin)              rel <= 1'b0;
         else if (rel_set && loaded)  rel <= 1'b1;
      end
   end

   assign tx_msb = tx_sh[DW-1];
endmodule

// File: rtl/i2c_slave_stretch.sv
module i2c_slave_stretch #(
   parameter int AW          = 7,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   output logic          scl_pull_o,
   output logic          sda_pull_o,
   input  logic [AW-1:0] own_addr_i,
   input  logic [DW-1:0] buf_wdata_i,
   input  logic          buf_wr_i,
   input  logic          buf_rd_i,
   output logic [DW-1:0] buf_rdata_o,
   output logic          buf_full_o,
   output logic          ovf_o,
   input  logic          ovf_clr_i,
   output logic          irq_o,
   input  logic          irq_clr_i,
   input  logic          rel_set_i,
   output logic          rel_o,
   output logic          rw_o
);
   import i2cs_pkg::*;

   localparam int CW = $clog2(DW + 1);
   localparam logic [CW-1:0] LAST_RX = CW'(DW);
   localparam logic [CW-1:0] LAST_TX = CW'(DW - 1);

   if (AW != DW - 1) begin : g_bad_width
      $error("i2c_slave_stretch: AW must equal DW-1");
   end

   // line conditioning
   logic [1:0] line_s;
   logic       scl_s, sda_s;
   logic       scl_rise, scl_fall, ev_start, ev_stop;

   i2cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (line_s)
   );
   assign scl_s = line_s[1];
   assign sda_s = line_s[0];

   i2cs_events u_ev (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (ev_start),
      .stop_ev  (ev_stop)
   );

   // protocol state
   st_e           st;
   logic [CW-1:0] cnt;
   logic [DW-1:0] rx_sh;
   logic          is_addr, ack_drv, go_send, drop, mack;

   logic tx_loaded, tx_msb, rel_q;
   logic addr_hit, byte_end, accept, refuse;
   logic rx_load, rw_load, irq_set, ovf_set, hold_begin, idle_reset, tx_shift;

   assign addr_hit = (rx_sh[DW-1:1] == own_addr_i);
   assign byte_end = (st == ST_RECV) && scl_fall && (cnt == LAST_RX);
   assign accept   = !buf_full_o && (!is_addr || addr_hit);
   assign refuse   = buf_full_o && (!is_addr || addr_hit);

   assign rx_load    = byte_end && accept;
   assign rw_load    = byte_end && accept && is_addr;
   assign ovf_set    = byte_end && refuse;
   assign irq_set    = scl_fall && ((st == ST_ACK) || (st == ST_MACK));
   assign hold_begin = scl_fall && (((st == ST_ACK) && !drop && go_send) ||
                                    ((st == ST_MACK) && !mack));
   assign idle_reset = scl_fall && (st == ST_MACK) && mack;
   assign tx_shift   = scl_fall && (st == ST_SEND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         rx_sh   <= '0;
         is_addr <= 1'b0;
         ack_drv <= 1'b0;
         go_send <= 1'b0;
         drop    <= 1'b0;
         mack    <= 1'b1;
      end else if (ev_stop) begin
         st <= ST_IDLE;
      end else if (ev_start) begin
         st      <= ST_RECV;
         cnt     <= '0;
         is_addr <= 1'b1;
      end else begin
         unique case (st)
            ST_RECV: begin
               if (scl_rise) begin
                  rx_sh <= {rx_sh[DW-2:0], sda_s};
                  cnt   <= cnt + 1'b1;
               end else if (byte_end) begin
                  if (is_addr && !addr_hit) begin
                     st <= ST_SKIP;
                  end else begin
                     st      <= ST_ACK;
                     ack_drv <= accept;
                     go_send <= is_addr && rx_sh[0] && accept;
                     drop    <= is_addr && !accept;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  cnt     <= '0;
                  is_addr <= 1'b0;
                  ack_drv <= 1'b0;
                  if (drop)         st <= ST_SKIP;
                  else if (go_send) st <= ST_HOLD;
                  else              st <= ST_RECV;
               end
            end
            ST_HOLD: begin
               if (rel_q) begin
                  st  <= ST_SEND;
                  cnt <= '0;
               end
            end
            ST_SEND: begin
               if (scl_fall) begin
                  if (cnt == LAST_TX) begin
                     st  <= ST_MACK;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) mack <= sda_s;
               else if (scl_fall) st <= mack ? ST_IDLE : ST_HOLD;
            end
            default: ;
         endcase
      end
   end

   i2cs_regs #(.DW(DW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wdata      (buf_wdata_i),
      .wr         (buf_wr_i),
      .rd         (buf_rd_i),
      .irq_clr    (irq_clr_i),
      .ovf_clr    (ovf_clr_i),
      .rel_set    (rel_set_i),
      .rx_load    (rx_load),
      .rx_data    (rx_sh),
      .rw_load    (rw_load),
      .rw_val     (rx_sh[0]),
      .rw_clr     (ev_stop),
      .irq_set    (irq_set),
      .ovf_set    (ovf_set),
      .hold_begin (hold_begin),
      .idle_reset (idle_reset),
      .tx_shift   (tx_shift),
      .buf_q      (buf_rdata_o),
      .full       (buf_full_o),
      .ovf        (ovf_o),
      .irq        (irq_o),
      .rw         (rw_o),
      .rel        (rel_q),
      .loaded     (tx_loaded),
      .tx_msb     (tx_msb)
   );

   assign rel_o      = rel_q;
   assign scl_pull_o = (st == ST_HOLD);
   assign sda_pull_o = ((st == ST_ACK) && ack_drv) || ((st == ST_SEND) && !tx_msb);
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_pull,
   input logic          sda_pull,
   input logic          ovf_flag,
   input logic [DW-1:0] buf_data,
   input logic          irq_flag,
   input logic          irq_clr,
   input logic          rel_bit,
   input logic          tx_loaded,
   input logic          stop_ev,
   input logic          scl_s
);
   // R2: a stop frees both lines on the next cycle
   p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> (!scl_pull && !sda_pull));

   // R5: a refused byte leaves the buffer as it was and gets no ACK
   p_keep_buf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> $stable(buf_data));
   p_no_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> !sda_pull);

   // R6: the event flag only drops on a clear pulse
   p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !irq_clr) |=> irq_flag);

   // R9: SCL is only freed after a buffer write (or by a stop)
   p_rel_needs_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_pull) |-> (tx_loaded || $past(stop_ev)));

   // R10: release bit is clear whenever a hold starts
   p_rel_autoclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_pull) |-> !rel_bit);

   // R11: SDA drive only moves while SCL is low
   p_sda_lo_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> !scl_s);
endmodule

bind i2c_slave_stretch i2cs_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_pull  (scl_pull_o),
   .sda_pull  (sda_pull_o),
   .ovf_flag  (ovf_o),
   .buf_data  (buf_rdata_o),
   .irq_flag  (irq_o),
   .irq_clr   (irq_clr_i),
   .rel_bit   (rel_o),
   .tx_loaded (tx_loaded),
   .stop_ev   (ev_stop),
   .scl_s     (scl_s)
);

// File: tb/i2c_slave_stretch_tb.sv
`timescale 1ns/1ps
module i2c_slave_stretch_tb;
   localparam int HP = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1, sda_m = 1'b1;
   logic       scl_pull, sda_pull;
   logic [6:0] own_addr = 7'h5A;
   logic [7:0] wdata = '0;
   logic       wr = 0, rd = 0, ovf_clr = 0, irq_clr = 0, rel_set = 0;
   logic [7:0] rdata;
   logic       full, ovf, irq, rel, rw;
   wire        scl_ln = scl_m & ~scl_pull;
   wire        sda_ln = sda_m & ~sda_pull;

   int n_tests = 0, n_fail = 0;
   bit chk_en = 0, done = 0;

   // behavioural model of processor-visible state
   logic [7:0] e_buf = '0;
   logic       e_full = 0, e_ovf = 0, e_irq = 0, e_rw = 0, e_rel = 0;

   always #5 clk = ~clk;

   i2c_slave_stretch u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_ln), .sda_i(sda_ln),
      .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .own_addr_i(own_addr),
      .buf_wdata_i(wdata), .buf_wr_i(wr), .buf_rd_i(rd), .buf_rdata_o(rdata),
      .buf_full_o(full), .ovf_o(ovf), .ovf_clr_i(ovf_clr), .irq_o(irq),
      .irq_clr_i(irq_clr), .rel_set_i(rel_set), .rel_o(rel), .rw_o(rw)
   );

   // per-clock comparison against the model (R4 R5 R6 R7 R8 R12)
   always @(negedge clk) begin
      if (chk_en && !done) begin
         n_tests++;
         if ({rdata, full, ovf, irq, rw, rel} !== {e_buf, e_full, e_ovf, e_irq, e_rw, e_rel}) begin
            n_fail++;
            $display("FAIL model R4 R5 R6 R8 R12: buf/full/ovf/irq/rw/rel act %h %b%b%b%b%b exp %h %b%b%b%b%b",
                     rdata, full, ovf, irq, rw, rel, e_buf, e_full, e_ovf, e_irq, e_rw, e_rel);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: act %h exp %h", req, act, exp);
      end
   endtask

   task automatic settle();
      tick(2);
      chk_en = 1;
   endtask

   task automatic wait_high();
      int t = 0;
      while (scl_ln !== 1'b1 && t < 4000) begin tick(1); t++; end
      if (t >= 4000) chk("R9 SCL never released", 8'(scl_ln), 8'h1);
   endtask

   task automatic bit_x(input logic b, output logic s);
      tick(4);
      sda_m = b;
      tick(HP);
      scl_m = 1;
      wait_high();
      tick(HP / 2);
      s = sda_ln;
      tick(HP / 2);
      scl_m = 0;
   endtask

   task automatic bus_start();
      chk_en = 0;
      tick(4); sda_m = 1; tick(4); scl_m = 1; tick(HP);
      sda_m = 0; tick(HP); scl_m = 0; tick(HP);
   endtask

   task automatic bus_stop();
      chk_en = 0;
      tick(4); sda_m = 0; tick(HP); scl_m = 1; wait_high(); tick(HP);
      sda_m = 1; tick(HP);
   endtask

   task automatic wr_byte(input logic [7:0] d, output logic ack);
      logic s;
      chk_en = 0;
      for (int i = 7; i >= 0; i--) bit_x(d[i], s);
      bit_x(1'b1, ack);
      tick(HP);
   endtask

   task automatic rd_byte(output logic [7:0] d, input logic mack);
      logic s;
      chk_en = 0;
      for (int i = 7; i >= 0; i--) begin bit_x(1'b1, s); d[i] = s; end
      bit_x(mack, s);
      tick(HP);
   endtask

   task automatic pulse(input int which);
      chk_en = 0;
      case (which)
         0: rd = 1; 1: wr = 1; 2: irq_clr = 1; 3: ovf_clr = 1; default: rel_set = 1;
      endcase
      tick(1);
      rd = 0; wr = 0; irq_clr = 0; ovf_clr = 0; rel_set = 0;
      tick(2);
   endtask

   task automatic report();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: act timeout exp completion");
      report();
   end

   initial begin
      logic       a;
      logic [7:0] d;
      tick(5);
      rst_n = 1;
      tick(3);
      // R1 reset state
      chk("R1 pulls", {6'b0, scl_pull, sda_pull}, 8'h00);
      chk("R1 flags", {3'b0, full, ovf, irq, rw, rel}, 8'h00);
      chk("R1 buffer", rdata, 8'h00);
      settle();

      // write transfer to own address
      bus_start();
      wr_byte(8'hB4, a);
      chk("R3 address ACK", 8'(a), 8'h0);
      e_buf = 8'hB4; e_full = 1; e_irq = 1; settle();
      pulse(0); e_full = 0; settle();
      chk("R7 read clears full", 8'(full), 8'h0);
      pulse(2); e_irq = 0; settle();
      wr_byte(8'hC3, a);
      chk("R4 data ACK", 8'(a), 8'h0);
      e_buf = 8'hC3; e_full = 1; e_irq = 1; settle();
      chk("R13 SDA free after ACK", 8'(sda_pull), 8'h0);
      wr_byte(8'h11, a);
      chk("R5 refused byte NACK", 8'(a), 8'h1);
      e_ovf = 1; settle();
      chk("R5 buffer kept", rdata, 8'hC3);
      chk("R6 event still set", 8'(irq), 8'h1);
      bus_stop(); settle();
      chk("R2 lines free after stop", {6'b0, scl_pull, sda_pull}, 8'h00);
      pulse(3); e_ovf = 0; pulse(2); e_irq = 0; pulse(0); e_full = 0; settle();

      // foreign address is ignored
      bus_start();
      wr_byte(8'h46, a);
      chk("R3 mismatch NACK", 8'(a), 8'h1);
      wr_byte(8'h00, a);
      chk("R3 data ignored", 8'(a), 8'h1);
      settle();
      chk("R3 no event", 8'(irq), 8'h0);
      chk("R3 buffer untouched", {full, rdata[6:0]}, {1'b0, 7'h43});
      bus_stop(); settle();

      // stop in the middle of a write transfer
      bus_start();
      wr_byte(8'hB4, a);
      e_buf = 8'hB4; e_full = 1; e_irq = 1; settle();
      bus_stop(); settle();
      chk("R2 stop mid transfer", {6'b0, scl_pull, sda_pull}, 8'h00);
      pulse(0); e_full = 0; pulse(2); e_irq = 0; settle();

      // read transfer with hold
      bus_start();
      wr_byte(8'hB5, a);
      chk("R8 read address ACK", 8'(a), 8'h0);
      e_buf = 8'hB5; e_full = 1; e_irq = 1; e_rw = 1; settle();
      tick(40);
      chk("R13 SCL held low", 8'(scl_pull), 8'h1);
      pulse(4); settle();
      chk("R9 release ignored without write", {6'b0, rel, scl_pull}, 8'h01);
      pulse(0); e_full = 0; pulse(2); e_irq = 0;
      wdata = 8'hA6; pulse(1); e_buf = 8'hA6; settle();
      chk("R9 still held after write", 8'(scl_pull), 8'h1);
      pulse(4); e_rel = 1; settle();
      chk("R9 SCL freed", 8'(scl_pull), 8'h0);
      rd_byte(d, 1'b0);
      chk("R11 first byte MSB first", d, 8'hA6);
      e_irq = 1; e_rel = 0; settle();
      chk("R10 release cleared on hold", 8'(rel), 8'h0);
      chk("R12 held again after ACK", 8'(scl_pull), 8'h1);
      pulse(2); e_irq = 0;
      wdata = 8'h3C; pulse(1); e_buf = 8'h3C;
      pulse(4); e_rel = 1; settle();
      rd_byte(d, 1'b1);
      chk("R11 second byte", d, 8'h3C);
      e_irq = 1; e_rw = 0; settle();
      chk("R12 free after NACK", {6'b0, scl_pull, rw}, 8'h00);
      bus_stop(); settle();
      chk("R2 final stop", {6'b0, scl_pull, sda_pull}, 8'h00);
      chk_en = 0;
      tick(2);
      report();
   end
endmodule